// File: doc/BRIEF.md
# Segmented Instruction Cache Controller

A read-only instruction cache placed between a processor fetch port and slow external program memory. It stores 64 words of 32 bits as two segments of 32 words. Each segment carries one 19-bit tag, and each word carries one present flag. A fetch whose tag matches and whose word is present is answered from local storage one cycle after the request. Any other fetch turns into a single-word read on the memory side.

Replacement works on whole segments. When the tag misses, the least recently used segment takes the new tag and all of its words are invalidated together. The requested word is then filled alone. When the tag matches but the word is absent, only that word is fetched and no other word is disturbed. A clear input drops every present flag. A freeze input keeps hits working but sends misses to memory without changing the tags or the data.

The controller is a three-state machine:
- `ST_IDLE` accepts requests. A hit or an idle cycle stays in `ST_IDLE`.
- An unfrozen miss moves to `ST_FILL`.
- A frozen miss moves to `ST_BYPASS`.
- Both `ST_FILL` and `ST_BYPASS` return to `ST_IDLE` in the cycle that memory signals ready.

Top module: `seg_icache`

## Requirements
- R1: The fetch address is split into two fields. Bits 23..5 form the tag, which is compared against both segment tags at once. Bits 4..0 pick the word inside the matching segment.
- R2: A hit is a request whose tag matches and whose word is present. On a hit, `rsp_valid_o` is 1 in the cycle after the request, with the stored word on `rsp_data_o`, and `mem_req_o` stays 0.
- R3: A request whose tag matches but whose word is absent produces one external read at the request address. That word then becomes present. The tag and the other words of that segment keep their state.
- R4: A request whose tag matches neither segment replaces the least recently used segment. That segment gets the new tag, all 32 of its present flags are cleared in the same cycle, and then the requested word is filled.
- R5: Every hit or fill makes the segment it uses the most recently used one. After reset, segment 0 is the first victim.
- R6: During an external read, `rsp_valid_o` stays 0 until `mem_ready_i` is 1. In that same cycle, `rsp_valid_o` is 1 and `rsp_data_o` equals `mem_data_i`.
- R7: Reset clears every present flag, and so does a one-cycle pulse on `clear_i`. A later fetch to a previously cached word therefore goes to memory.
- R8: While `freeze_i` is 1 at request time, hits are still served. A miss reads memory but changes no tag and no present flag, so the same word misses again after the freeze ends.
- R9: `req_ready_o` is 1 only in `ST_IDLE`, which allows one outstanding request. `mem_req_o` and `mem_addr_o` are held steady until `mem_ready_i` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Invalidate all cached words |
| freeze_i | input | 1 | Serve hits only; no replacement or fill |
| req_valid_i | input | 1 | Fetch request |
| req_addr_i | input | 24 | Fetch word address |
| req_ready_o | output | 1 | Controller can accept a request |
| rsp_valid_o | output | 1 | Fetch data valid |
| rsp_data_o | output | 32 | Fetch data |
| mem_req_o | output | 1 | External single-word read request |
| mem_addr_o | output | 24 | External read address |
| mem_ready_i | input | 1 | External read complete |
| mem_data_i | input | 32 | External read data |

## Verification
The hardest situation to reach from the ports is an eviction driven by LRU order that removes a segment which has just been used. Two properties have to be shown together: that the victim is the older of the two segments, and that clearing all 32 flags of the victim does not touch the other segment. The stimulus table walks three distinct tags through the two segments in an order that makes the victim alternate. It then revisits words of both the evicted and the surviving segments. Frozen misses followed by unfrozen retries show that nothing was cached during the freeze.

// File: rtl/seg_icache_pkg.sv
package seg_icache_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 5;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int WORDS  = 1 << OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_BYPASS
    } ctrl_state_e;
endpackage

// File: rtl/seg_icache_dir.sv
module seg_icache_dir #(
    parameter int ADDR_W = seg_icache_pkg::ADDR_W,
    parameter int OFF_W  = seg_icache_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] look_addr_i,
    input  logic              alloc_i,
    input  logic              touch_i,
    input  logic              touch_seg_i,
    input  logic              set_i,
    input  logic              set_seg_i,
    input  logic [OFF_W-1:0]  set_word_i,
    output logic              match_o,
    output logic              match_seg_o,
    output logic              hit_o,
    output logic              victim_o
);
    localparam int SEGS  = 2;
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int WORDS = 1 << OFF_W;

    logic [TAG_W-1:0]            tag_q [SEGS];
    logic [SEGS-1:0][WORDS-1:0]  pres_q;
    logic                        lru_q;
    logic [SEGS-1:0]             match_vec;
    logic [SEGS-1:0]             present_vec;
    logic [TAG_W-1:0]            look_tag;
    logic [OFF_W-1:0]            look_word;

    assign look_tag  = look_addr_i[ADDR_W-1:OFF_W];
    assign look_word = look_addr_i[OFF_W-1:0];

    // Parallel compare of both segment tags
    for (genvar s = 0; s < SEGS; s++) begin : g_cmp
        assign match_vec[s]   = (tag_q[s] == look_tag);
        assign present_vec[s] = match_vec[s] & pres_q[s][look_word];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[s] <= TAG_W'(s);
            end else if (alloc_i && (lru_q == 1'(s))) begin
                tag_q[s] <= look_tag;
            end
        end
    end

    assign match_o     = |match_vec;
    assign match_seg_o = match_vec[1];
    assign hit_o       = |present_vec;
    assign victim_o    = lru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= '0;
        end else if (clear_i) begin
            pres_q <= '0;
        end else begin
            if (alloc_i) begin
                pres_q[lru_q] <= '0;
            end
            if (set_i) begin
                pres_q[set_seg_i][set_word_i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= 1'b0;
        end else if (touch_i) begin
            lru_q <= ~touch_seg_i;
        end
    end

    assert_tags_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tag_q[0] != tag_q[1]);
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pres_q == '0));
    assert_alloc_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !clear_i) |=> (pres_q[$past(lru_q)] == '0));
    assert_lru_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> (lru_q != $past(touch_seg_i)));
endmodule

// File: rtl/seg_icache_data.sv
module seg_icache_data #(
    parameter int DATA_W = seg_icache_pkg::DATA_W,
    parameter int IDX_W  = seg_icache_pkg::OFF_W + 1
) (
    input  logic              clk,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_i) begin
            store_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = store_q[rd_idx_i];
endmodule

// File: rtl/seg_icache_ctrl.sv
module seg_icache_ctrl
    import seg_icache_pkg::*;
#(
    parameter int ADDR_W = seg_icache_pkg::ADDR_W,
    parameter int DATA_W = seg_icache_pkg::DATA_W,
    parameter int OFF_W  = seg_icache_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              freeze_i,
    input  logic              hit_i,
    input  logic              match_i,
    input  logic              match_seg_i,
    input  logic              victim_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              alloc_o,
    output logic              touch_o,
    output logic              touch_seg_o,
    output logic              set_o,
    output logic              set_seg_o,
    output logic [OFF_W-1:0]  set_word_o
);
    ctrl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              seg_q;
    logic              hit_q;
    logic [DATA_W-1:0] hit_data_q;

    logic accept, take_hit, go_fill, go_byp, done, use_seg;

    assign accept   = (state_q == ST_IDLE) && req_valid_i;
    assign take_hit = accept && hit_i;
    assign go_fill  = accept && !hit_i && !freeze_i;
    assign go_byp   = accept && !hit_i && freeze_i;
    assign done     = (state_q != ST_IDLE) && mem_ready_i;
    assign use_seg  = match_i ? match_seg_i : victim_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_fill)     state_d = ST_FILL;
                else if (go_byp) state_d = ST_BYPASS;
            end
            ST_FILL:   if (mem_ready_i) state_d = ST_IDLE;
            ST_BYPASS: if (mem_ready_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and hit response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            seg_q      <= 1'b0;
            hit_q      <= 1'b0;
            hit_data_q <= '0;
        end else begin
            hit_q <= take_hit;
            if (take_hit) begin
                hit_data_q <= rd_data_i;
            end
            if (go_fill || go_byp) begin
                addr_q <= req_addr_i;
                seg_q  <= use_seg;
            end
        end
    end

    // Output logic
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        mem_req_o   = (state_q != ST_IDLE);
        mem_addr_o  = addr_q;
        rsp_valid_o = hit_q || done;
        rsp_data_o  = done ? mem_data_i : hit_data_q;
        alloc_o     = go_fill && !match_i;
        touch_o     = take_hit || go_fill;
        touch_seg_o = use_seg;
        set_o       = (state_q == ST_FILL) && mem_ready_i;
        set_seg_o   = seg_q;
        set_word_o  = addr_q[OFF_W-1:0];
    end

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_hit |=> (rsp_valid_o && !mem_req_o));
    assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));
    assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |-> !rsp_valid_o);
    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_o);
    assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i) |-> (rsp_valid_o && rsp_data_o == mem_data_i));
endmodule

// File: rtl/seg_icache.sv
module seg_icache
    import seg_icache_pkg::*;
#(
    parameter int ADDR_W = seg_icache_pkg::ADDR_W,
    parameter int DATA_W = seg_icache_pkg::DATA_W,
    parameter int OFF_W  = seg_icache_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              freeze_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_data_i
);
    localparam int IDX_W = OFF_W + 1;

    logic             match_w, match_seg_w, hit_w, victim_w;
    logic             alloc_w, touch_w, touch_seg_w, set_w, set_seg_w;
    logic [OFF_W-1:0] set_word_w;
    logic [DATA_W-1:0] rd_data_w;

    seg_icache_dir #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dir (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .look_addr_i (req_addr_i),
        .alloc_i     (alloc_w),
        .touch_i     (touch_w),
        .touch_seg_i (touch_seg_w),
        .set_i       (set_w),
        .set_seg_i   (set_seg_w),
        .set_word_i  (set_word_w),
        .match_o     (match_w),
        .match_seg_o (match_seg_w),
        .hit_o       (hit_w),
        .victim_o    (victim_w)
    );

    seg_icache_data #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_data (
        .clk       (clk),
        .wr_i      (set_w),
        .wr_idx_i  ({set_seg_w, set_word_w}),
        .wr_data_i (mem_data_i),
        .rd_idx_i  ({match_seg_w, req_addr_i[OFF_W-1:0]}),
        .rd_data_o (rd_data_w)
    );

    seg_icache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_addr_i  (req_addr_i),
        .freeze_i    (freeze_i),
        .hit_i       (hit_w),
        .match_i     (match_w),
        .match_seg_i (match_seg_w),
        .victim_i    (victim_w),
        .rd_data_i   (rd_data_w),
        .mem_ready_i (mem_ready_i),
        .mem_data_i  (mem_data_i),
        .req_ready_o (req_ready_o),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .alloc_o     (alloc_w),
        .touch_o     (touch_w),
        .touch_seg_o (touch_seg_w),
        .set_o       (set_w),
        .set_seg_o   (set_seg_w),
        .set_word_o  (set_word_w)
    );

    assert_frozen_no_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && req_ready_o) |-> (!alloc_w && !touch_w || (touch_w && hit_w)));
    assert_hit_no_memreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready_o && req_valid_i && hit_w) |=> !mem_req_o);
endmodule

// File: tb/seg_icache_bench.sv
module seg_icache_bench;
    typedef struct packed {
        logic [23:0] addr;
        logic        frz;
        logic        hit;
        logic [1:0]  lat;
    } vec_t;

    // Expected hit/miss per fetch, from the tag/LRU/present rules (R1,R3,R4,R5,R8)
    localparam vec_t [0:16] VECS = '{
        '{24'h000100, 1'b0, 1'b0, 2'd0},  // tag miss -> seg0 replaced (R4,R5)
        '{24'h000100, 1'b0, 1'b1, 2'd1},  // hit (R2)
        '{24'h000104, 1'b0, 1'b0, 2'd2},  // word miss same tag (R1,R3)
        '{24'h000200, 1'b0, 1'b0, 2'd3},  // tag miss -> seg1
        '{24'h000100, 1'b0, 1'b1, 2'd0},  // hit seg0, seg1 now LRU
        '{24'h000300, 1'b0, 1'b0, 2'd1},  // evict seg1 (R5)
        '{24'h000104, 1'b0, 1'b1, 2'd0},  // seg0 kept both words (R3)
        '{24'h000200, 1'b0, 1'b0, 2'd2},  // evicted tag misses again
        '{24'h000300, 1'b0, 1'b0, 2'd0},  // evict seg0
        '{24'h000100, 1'b0, 1'b0, 2'd1},  // evict seg1
        '{24'h000300, 1'b0, 1'b1, 2'd0},  // survivor hits
        '{24'h000104, 1'b1, 1'b0, 2'd2},  // frozen word miss, bypass (R8)
        '{24'h000104, 1'b0, 1'b0, 2'd0},  // still absent after freeze (R8,R4)
        '{24'h000300, 1'b1, 1'b1, 2'd1},  // frozen hit served (R8)
        '{24'h000400, 1'b1, 1'b0, 2'd3},  // frozen tag miss, bypass
        '{24'h000300, 1'b0, 1'b1, 2'd0},  // no replacement during freeze
        '{24'h000100, 1'b0, 1'b1, 2'd0}   // word 0 survived word-4 fill
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        freeze_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [23:0] req_addr_i = '0;
    logic        req_ready_o;
    logic        rsp_valid_o;
    logic [31:0] rsp_data_o;
    logic        mem_req_o;
    logic [23:0] mem_addr_o;
    logic        mem_ready_i = 1'b0;
    logic [31:0] mem_data_i = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5ns clk = ~clk;

    seg_icache u_seg_icache (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .freeze_i    (freeze_i),
        .req_valid_i (req_valid_i),
        .req_addr_i  (req_addr_i),
        .req_ready_o (req_ready_o),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ready_i (mem_ready_i),
        .mem_data_i  (mem_data_i)
    );

    function automatic logic [31:0] mem_word(input logic [23:0] a);
        return {8'hC5, a} ^ {a[7:0], 24'h00A5F0};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic frz, input logic exp_hit, input int lat);
        logic got_hit;
        @(negedge clk);
        chk(req_ready_o == 1'b1, "R9 ready in idle", 32'(req_ready_o), 32'd1);
        req_valid_i = 1'b1;
        req_addr_i  = a;
        freeze_i    = frz;
        @(negedge clk);
        req_valid_i = 1'b0;
        got_hit = rsp_valid_o && !mem_req_o;
        chk(got_hit == exp_hit, "R1,R3,R4,R5,R8 hit/miss", 32'(got_hit), 32'(exp_hit));
        if (rsp_valid_o)
            chk(rsp_data_o == mem_word(a), "R2 hit data", rsp_data_o, mem_word(a));
        if (mem_req_o) begin
            chk(mem_addr_o == a, "R3 external address", 32'(mem_addr_o), 32'(a));
            chk(!rsp_valid_o, "R6 no early valid", 32'(rsp_valid_o), 32'd0);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(mem_req_o && !rsp_valid_o && mem_addr_o == a, "R9 held request",
                    {30'd0, mem_req_o, rsp_valid_o}, 32'd2);
            end
            mem_data_i  = mem_word(a);
            mem_ready_i = 1'b1;
            #1ns;
            chk(rsp_valid_o && rsp_data_o == mem_word(a), "R6 forwarded word",
                rsp_data_o, mem_word(a));
            @(negedge clk);
            mem_ready_i = 1'b0;
            chk(req_ready_o && !rsp_valid_o, "R9 back to idle",
                {30'd0, req_ready_o, rsp_valid_o}, 32'd2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R7 reset outputs",
            {29'd0, req_ready_o, rsp_valid_o, mem_req_o}, 32'd4);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            access(VECS[i].addr, VECS[i].frz, VECS[i].hit, int'(VECS[i].lat));
        end

        // R7: clear drops every present flag
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        access(24'h000300, 1'b0, 1'b0, 1);   // R7 miss after clear
        access(24'h000300, 1'b0, 1'b1, 0);   // refilled
        access(24'h000100, 1'b0, 1'b0, 0);   // R7 other segment cleared too

        // R7: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(24'h000100, 1'b0, 1'b0, 0);   // R7 miss after reset
        // R5: first victim after reset is segment 0; next tag goes to segment 1
        access(24'h000500, 1'b0, 1'b0, 0);
        access(24'h000100, 1'b0, 1'b1, 0);   // R5 both retained
        access(24'h000500, 1'b0, 1'b1, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule